// File: doc/BRIEF.md
# Command-Controlled 14-bit Down-Counting Timer

This block is a 14-bit down-counter that runs from its own timer clock and is set up from a host bus in a different clock domain. The host writes three byte-wide locations. A low count byte and a high byte together hold the period length. The high byte also carries a two-bit output-mode field. A command byte carries a two-bit run control. Each accepted host write crosses into the timer domain through a toggle request and acknowledge handshake with two-flop synchronizers in each direction. While a write is in flight, the host sees `wr_ready` low.

Once started, the counter steps down from its period length N to 1. The cycle in which it holds 1 is the terminal count (TC). The output `tmr_out` can show one low cycle at each TC, or a square wave that is high for the first half of each period. In the continuous modes the period repeats, and the counter reloads from the count registers at every TC. In the single-shot modes the timer stops at TC. The command field can start the timer, stop it at once, let it stop at the next TC, or ask for a reload at the next TC.

Top module: `tmr14_top`

## Requirements
- R1: After reset, and whenever the timer is stopped, `tmr_out` is 1. After reset, `wr_ready` is 1.
- R2: The period length N is {high byte bits 5:0, low byte}. The low byte is at address 4 and the high byte at address 5. Over one period the counter spends exactly N timer-clock cycles, and N below 2 acts as 2.
- R3: High-byte bit 6 set selects continuous operation and clear selects single shot. Bit 7 clear selects square wave: `tmr_out` is high for ceil(N/2) cycles, then low for floor(N/2) cycles.
- R4: High-byte bit 7 set selects pulse output: `tmr_out` is low for exactly the one TC cycle of each period and high otherwise.
- R5: In a single-shot mode the timer stops after its first TC and `tmr_out` stays high from then on.
- R6: The command is bits 7:6 of a write to address 0. Code 00 changes nothing, whether the timer is running or stopped.
- R7: Code 01 stops a running timer at once, and `tmr_out` goes high. On a stopped timer it has no effect.
- R8: Code 10 lets a running timer finish its current period, shows that TC, and then stops it.
- R9: Code 11 starts a stopped timer with the current registers. On a running timer it makes the next TC reload from the registers, even in a single-shot mode.
- R10: An accepted write (`wr_en` with `wr_ready` high) drops `wr_ready` on the next host clock until the write is delivered. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Host-domain synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Write address: 0 command, 4 low count, 5 high count/mode |
| wr_data | input | 8 | Write data |
| wr_ready | output | 1 | High when a new write can be accepted |
| tclk | input | 1 | Timer clock |
| tmr_rst | input | 1 | Timer-domain synchronous reset, active high |
| tmr_out | output | 1 | Timer output waveform |

## Verification
The continuous square wave is run with an odd and an even period. This separates the ceiling split from a plain half split. Pulse mode is run with a period above 255 to exercise the high count byte, and with a zero length to exercise the minimum of 2. Single-shot runs count the low cycles in a long window: one low for a pulse, a half period of low for a square wave. That tells a stop at TC from free running. The stop-at-TC and reload-at-TC commands are told apart from an immediate stop and from a plain run by the exact number of TC pulses seen after the command.

// File: rtl/tmr14_pkg.sv
package tmr14_pkg;

    localparam int OFS_CMD = 0;
    localparam int OFS_LO  = 4;
    localparam int OFS_HI  = 5;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_HALT    = 2'b01,
        CMD_HALT_TC = 2'b10,
        CMD_RUN     = 2'b11
    } tcmd_e;

    // high-byte bits 7:6: pulse selects pulse output, cont selects continuous
    typedef struct packed {
        logic pulse;
        logic cont;
    } omode_t;

    function automatic logic addr_is(input logic [7:0] a, input int ofs);
        return a == 8'(ofs);
    endfunction

endpackage

// File: rtl/tmr14_host_port.sv
module tmr14_host_port #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    output logic              wr_ready
);
    logic ack_s1, ack_s2;

    assign wr_ready = (req_tgl == ack_s2);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_s1    <= 1'b0;
            ack_s2    <= 1'b0;
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
            if (wr_en && wr_ready) begin
                hold_addr <= wr_addr;
                hold_data <= wr_data;
                req_tgl   <= ~req_tgl;
            end
        end
    end
endmodule

// File: rtl/tmr14_sync_rx.sv
module tmr14_sync_rx (
    input  logic tclk,
    input  logic tmr_rst,
    input  logic req_tgl,
    output logic ack_tgl,
    output logic evt
);
    logic r1, r2;

    assign evt = r2 ^ ack_tgl;

    always_ff @(posedge tclk) begin
        if (tmr_rst) begin
            r1      <= 1'b0;
            r2      <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            r1      <= req_tgl;
            r2      <= r1;
            ack_tgl <= r2;
        end
    end
endmodule

// File: rtl/tmr14_core.sv
module tmr14_core
    import tmr14_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              tclk,
    input  logic              tmr_rst,
    input  logic              evt,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output logic              running,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cur_len,
    output omode_t            cur_mode
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);
    localparam logic [CNT_W-1:0] TC_VAL  = CNT_W'(1);

    logic [DATA_W-1:0] lo_q, hi_q;
    logic              pend_stop, pend_reload;
    logic [CNT_W-1:0]  raw_len, reg_len;
    omode_t            reg_mode;
    tcmd_e             cmd;
    logic              is_cmd, is_lo, is_hi, at_tc;

    always_comb begin
        raw_len  = {hi_q[HI_W-1:0], lo_q};
        reg_len  = (raw_len < MIN_LEN) ? MIN_LEN : raw_len;
        reg_mode = omode_t'(hi_q[DATA_W-1 -: 2]);
        cmd      = tcmd_e'(ev_data[DATA_W-1 -: 2]);
        is_cmd   = evt && addr_is(8'(ev_addr), OFS_CMD);
        is_lo    = evt && addr_is(8'(ev_addr), OFS_LO);
        is_hi    = evt && addr_is(8'(ev_addr), OFS_HI);
        at_tc    = (count == TC_VAL);
    end

    always_ff @(posedge tclk) begin
        if (tmr_rst) begin
            lo_q        <= '0;
            hi_q        <= '0;
            running     <= 1'b0;
            pend_stop   <= 1'b0;
            pend_reload <= 1'b0;
            count       <= MIN_LEN;
            cur_len     <= MIN_LEN;
            cur_mode    <= '0;
        end else begin
            if (is_lo) lo_q <= ev_data;
            if (is_hi) hi_q <= ev_data;

            if (running) begin
                if (at_tc) begin
                    if (pend_stop) begin
                        running     <= 1'b0;
                        pend_stop   <= 1'b0;
                        pend_reload <= 1'b0;
                    end else if (cur_mode.cont || pend_reload) begin
                        count       <= reg_len;
                        cur_len     <= reg_len;
                        cur_mode    <= reg_mode;
                        pend_reload <= 1'b0;
                    end else begin
                        running <= 1'b0;
                    end
                end else begin
                    count <= count - TC_VAL;
                end
            end

            // a command in the same cycle overrides the counting step
            if (is_cmd) begin
                case (cmd)
                    CMD_HALT: begin
                        if (running) begin
                            running     <= 1'b0;
                            pend_stop   <= 1'b0;
                            pend_reload <= 1'b0;
                        end
                    end
                    CMD_HALT_TC: begin
                        if (running) pend_stop <= 1'b1;
                    end
                    CMD_RUN: begin
                        if (!running) begin
                            running     <= 1'b1;
                            count       <= reg_len;
                            cur_len     <= reg_len;
                            cur_mode    <= reg_mode;
                            pend_stop   <= 1'b0;
                            pend_reload <= 1'b0;
                        end else begin
                            pend_reload <= 1'b1;
                            pend_stop   <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr14_wave.sv
module tmr14_wave
    import tmr14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             running,
    input  omode_t           mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cur_len,
    output logic             tmr_out
);
    always_comb begin
        if (!running)
            tmr_out = 1'b1;
        else if (mode.pulse)
            tmr_out = (count != CNT_W'(1));
        else
            tmr_out = (count > (cur_len >> 1));
    end
endmodule

// File: rtl/tmr14_top.sv
module tmr14_top
    import tmr14_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              tclk,
    input  logic              tmr_rst,
    output logic              tmr_out
);
    logic              req_tgl, ack_tgl, evt;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic              running;
    logic [CNT_W-1:0]  count, cur_len;
    omode_t            cur_mode;

    tmr14_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ack_tgl(ack_tgl), .req_tgl(req_tgl),
        .hold_addr(hold_addr), .hold_data(hold_data), .wr_ready(wr_ready)
    );

    tmr14_sync_rx u_rx (
        .tclk(tclk), .tmr_rst(tmr_rst), .req_tgl(req_tgl),
        .ack_tgl(ack_tgl), .evt(evt)
    );

    tmr14_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .tclk(tclk), .tmr_rst(tmr_rst), .evt(evt), .ev_addr(hold_addr),
        .ev_data(hold_data), .running(running), .count(count),
        .cur_len(cur_len), .cur_mode(cur_mode)
    );

    tmr14_wave #(.CNT_W(CNT_W)) u_wave (
        .running(running), .mode(cur_mode), .count(count),
        .cur_len(cur_len), .tmr_out(tmr_out)
    );
endmodule

// File: rtl/tmr14_chk.sv
module tmr14_chk
    import tmr14_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_ready,
    input logic              tclk,
    input logic              tmr_rst,
    input logic              evt,
    input logic [ADDR_W-1:0] ev_addr,
    input logic [DATA_W-1:0] ev_data,
    input logic              running,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cur_len,
    input omode_t            cur_mode,
    input logic              tmr_out
);
    logic cmd_halt, cmd_run;
    assign cmd_halt = evt && (ev_addr == ADDR_W'(OFS_CMD)) && (ev_data[DATA_W-1 -: 2] == 2'b01);
    assign cmd_run  = evt && (ev_addr == ADDR_W'(OFS_CMD)) && (ev_data[DATA_W-1 -: 2] == 2'b11);

    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ready) |=> !wr_ready);

    p_idle_high_r1: assert property (@(posedge tclk) disable iff (tmr_rst)
        !running |-> tmr_out);

    p_count_range_r2: assert property (@(posedge tclk) disable iff (tmr_rst)
        running |-> (count != '0) && (count <= cur_len));

    p_pulse_width_r4: assert property (@(posedge tclk) disable iff (tmr_rst)
        (running && cur_mode.pulse && !tmr_out) |=> tmr_out);

    p_halt_now_r7: assert property (@(posedge tclk) disable iff (tmr_rst)
        cmd_halt |=> !running);

    p_start_r9: assert property (@(posedge tclk) disable iff (tmr_rst)
        (cmd_run && !running) |=> running);
endmodule

bind tmr14_top tmr14_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ready(wr_ready),
    .tclk(tclk), .tmr_rst(tmr_rst), .evt(evt), .ev_addr(hold_addr),
    .ev_data(hold_data), .running(running), .count(count),
    .cur_len(cur_len), .cur_mode(cur_mode), .tmr_out(tmr_out)
);

// File: tb/tmr14_top_test.sv
module tmr14_top_test;
    localparam int CLK_PERIOD  = 10;
    localparam int TCLK_PERIOD = 16;
    localparam int WATCHDOG    = 2_000_000;

    logic       clk = 1'b0, tclk = 1'b0;
    logic       rst = 1'b1, tmr_rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_ready, tmr_out;
    int         checks = 0, errors = 0;
    int         low_cnt = 0;

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(TCLK_PERIOD/2) tclk = ~tclk;

    tmr14_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .tclk(tclk),
        .tmr_rst(tmr_rst), .tmr_out(tmr_out)
    );

    always @(negedge tclk) if (!tmr_rst && !tmr_out) low_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        while (!wr_ready) @(negedge clk);
    endtask

    task automatic start_tmr(input int len, input logic [7:0] mode_bits);
        wr(3'd4, 8'(len));
        wr(3'd5, mode_bits | 8'((len >> 8) & 8'h3f));
        wr(3'd0, 8'hC0);
    endtask

    task automatic stop_tmr();
        wr(3'd0, 8'h40);
        repeat (4) @(negedge tclk);
    endtask

    task automatic tcycles(input int n);
        repeat (n) @(negedge tclk);
        #1;
    endtask

    task automatic measure(output int hi, output int lo);
        int guard = 0;
        logic prev;
        hi = 0; lo = 0;
        @(negedge tclk); prev = tmr_out;
        forever begin
            @(negedge tclk);
            if (prev && !tmr_out) break;
            prev = tmr_out;
            if (++guard > 20000) return;
        end
        lo = 1;
        forever begin @(negedge tclk); if (tmr_out) break; lo++; end
        hi = 1;
        forever begin @(negedge tclk); if (!tmr_out) break; hi++; end
    endtask

    task automatic t_reset();
        chk(tmr_out === 1'b1, "R1 reset output", int'(tmr_out), 1);
        chk(wr_ready === 1'b1, "R1 reset ready", int'(wr_ready), 1);
    endtask

    task automatic t_square();
        int hi, lo;
        start_tmr(5, 8'h40);
        measure(hi, lo);
        chk(hi == 3, "R3 odd square high", hi, 3);
        chk(lo == 2, "R3 odd square low", lo, 2);
        stop_tmr();
        start_tmr(8, 8'h40);
        measure(hi, lo);
        chk(hi == 4 && lo == 4, "R3 even square high+low", hi*100+lo, 404);
        stop_tmr();
    endtask

    task automatic t_pulse();
        int hi, lo;
        start_tmr(300, 8'hC0);
        measure(hi, lo);
        chk(lo == 1, "R4 pulse low width", lo, 1);
        chk(hi == 299, "R2 period via high byte", hi, 299);
        stop_tmr();
        start_tmr(0, 8'hC0);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R2 zero length as two", hi*100+lo, 101);
        stop_tmr();
    endtask

    task automatic t_single();
        int base;
        tcycles(1); base = low_cnt;
        start_tmr(10, 8'h80);
        tcycles(40);
        chk(low_cnt - base == 1, "R5 single pulse count", low_cnt - base, 1);
        chk(tmr_out === 1'b1, "R5 single pulse idle high", int'(tmr_out), 1);
        base = low_cnt;
        start_tmr(6, 8'h00);
        tcycles(30);
        chk(low_cnt - base == 3, "R5 R3 single square lows", low_cnt - base, 3);
    endtask

    task automatic t_nop_halt();
        int base;
        start_tmr(4, 8'hC0);
        wr(3'd0, 8'h00);
        tcycles(1); base = low_cnt;
        tcycles(20);
        chk(low_cnt - base == 5, "R6 nop while running", low_cnt - base, 5);
        wr(3'd0, 8'h40);
        tcycles(1); base = low_cnt;
        tcycles(20);
        chk(low_cnt - base == 0, "R7 halt immediate", low_cnt - base, 0);
        chk(tmr_out === 1'b1, "R7 halt output high", int'(tmr_out), 1);
        wr(3'd0, 8'h40);
        wr(3'd0, 8'h00);
        tcycles(1); base = low_cnt;
        tcycles(20);
        chk(low_cnt - base == 0, "R6 R7 no start from stopped", low_cnt - base, 0);
    endtask

    task automatic t_halt_tc();
        int hi, lo, base;
        start_tmr(20, 8'hC0);
        measure(hi, lo);
        tcycles(0); base = low_cnt;
        wr(3'd0, 8'h80);
        tcycles(80);
        chk(low_cnt - base == 1, "R8 one more TC then stop", low_cnt - base, 1);
        chk(tmr_out === 1'b1, "R8 stopped high", int'(tmr_out), 1);
    endtask

    task automatic t_reload();
        int base;
        tcycles(1); base = low_cnt;
        start_tmr(30, 8'h80);
        wr(3'd4, 8'd5);
        wr(3'd0, 8'hC0);
        tcycles(80);
        chk(low_cnt - base == 2, "R9 reload at TC in single mode", low_cnt - base, 2);
        chk(tmr_out === 1'b1, "R9 stops after reload period", int'(tmr_out), 1);
    endtask

    task automatic t_ready();
        int base;
        tcycles(1); base = low_cnt;
        @(negedge clk);
        wr_addr = 3'd3; wr_data = 8'hC0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(wr_ready === 1'b0, "R10 ready drops", int'(wr_ready), 0);
        while (!wr_ready) @(negedge clk);
        tcycles(20);
        chk(low_cnt - base == 0, "R10 other address ignored", low_cnt - base, 0);
    endtask

    initial begin
        #(WATCHDOG);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge tclk);
        @(negedge clk); rst = 1'b0;
        @(negedge tclk); tmr_rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_square();
        t_pulse();
        t_single();
        t_nop_halt();
        t_halt_tc();
        t_reload();
        t_ready();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule